// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the address datapath of one DMA channel. It holds a source address and a destination address. It moves both of them through a transfer made of bursts, and a transfer is a sequence of one or more bursts. The data mover sends a `step` pulse each time one word has been read and written. The generator then advances each address by one of three signed offsets, picked by where that word falls:

- inside a burst, the burst step is added;
- at a burst boundary, the transfer step is added;
- at a burst boundary where the side's wrap counter has run out, the side's begin address moves by the wrap step and the current address jumps to it.

Software fills shadow copies of the begin and current addresses for each side. A `start` pulse copies them into the working registers and reloads every counter. An optional sync input resets the wrap counter of one chosen side, which lets an outside event realign a circular buffer. Pulses mark the end of each burst and the end of the whole transfer. In 32-bit word mode the presented addresses are even.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `busy`, `burst_done` and `xfer_done` are 0 and both address outputs are 0.
- R2: A `start` pulse loads both shadow current addresses onto the address outputs and sets `busy` on the next cycle. It reloads all counters, whether a transfer is running or not, and a `step` in the same cycle is ignored.
- R3: A size field holding N means N+1 units. While `busy`, a `step` on a word that is not the last of its burst adds that side's signed 16-bit burst step to each address.
- R4: A `step` on the last word of a burst that is not the final burst adds the signed transfer step to a side whose wrap counter is not zero, and that counter decrements by one.
- R5: On the same event, a side whose wrap counter is zero adds its signed wrap step to its begin address, takes the new begin address as its current address, and reloads the counter from its wrap size. The two sides wrap independently, so with wrap size W a side wraps after every W+1 bursts.
- R6: When `sync_en` is 1, a `sync_in` pulse during a transfer reloads the wrap counter of the destination side if `sync_sel` is 1, or of the source side if it is 0. This takes effect after any boundary update in that cycle. When `sync_en` is 0, `sync_in` has no effect.
- R7: `burst_done` is high for one cycle after the last word of each burst. `xfer_done` is high together with it only after the last word of the last burst, so a transfer of sizes B and T gives T+1 burst pulses and one transfer pulse after (B+1)(T+1) steps.
- R8: After the final word `busy` is 0, the addresses do not move, and `step` pulses raise no done pulse until the next `start`.
- R9: When `wide` is 1, bit 0 of both address outputs reads 0. The other bits show the current address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load shadow addresses and counters, begin a transfer |
| step | input | 1 | One word has been moved |
| sync_in | input | 1 | External realignment event |
| sync_en | input | 1 | Let `sync_in` act |
| sync_sel | input | 1 | 0: sync acts on source wrap counter, 1: on destination |
| wide | input | 1 | 1: 32-bit words, addresses shown even |
| burst_size | input | 5 | Words per burst minus one |
| xfer_size | input | 16 | Bursts per transfer minus one |
| src_beg_sh | input | 32 | Source begin address shadow |
| src_addr_sh | input | 32 | Source current address shadow |
| dst_beg_sh | input | 32 | Destination begin address shadow |
| dst_addr_sh | input | 32 | Destination current address shadow |
| src_burst_step | input | 16 | Signed source step inside a burst |
| dst_burst_step | input | 16 | Signed destination step inside a burst |
| src_xfer_step | input | 16 | Signed source step between bursts |
| dst_xfer_step | input | 16 | Signed destination step between bursts |
| src_wrap_size | input | 16 | Source bursts per wrap minus one |
| dst_wrap_size | input | 16 | Destination bursts per wrap minus one |
| src_wrap_step | input | 16 | Signed source begin-address step at wrap |
| dst_wrap_step | input | 16 | Signed destination begin-address step at wrap |
| busy | output | 1 | Transfer in progress |
| burst_done | output | 1 | Pulse: a burst finished |
| xfer_done | output | 1 | Pulse: the transfer finished |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
Back-to-back steps with a positive source step and a negative destination step tell the burst, transfer and wrap offsets apart. The two sides use different wrap sizes, so a counter shared between them would show. Steps with random idle gaps show that only `step` advances the state. A short run with one-word bursts, a lone sync pulse and then sync disabled tells a realigned wrap from a free-running one. Restarting mid-transfer, odd shadow addresses in wide mode and one-word, one-burst transfers cover the reload, alignment and zero-size edges.

// File: rtl/dma_ag_pkg.sv
// Package: shared command encoding for the address generator.
// Assumes two sides per channel, index 0 = source, index 1 = destination.
package dma_ag_pkg;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_SRC  = 0;
    localparam int SIDE_DST  = 1;

    // What the sequencer asks each address side to do on a clock edge.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,   // hold
        CMD_WORD  = 2'd1,   // word inside a burst finished
        CMD_BURST = 2'd2,   // last word of a non-final burst finished
        CMD_LAST  = 2'd3    // last word of the transfer finished
    } ag_cmd_e;
endpackage

// File: rtl/dma_ag_seq.sv
// Module: dma_ag_seq
// Counts words per burst and bursts per transfer, owns the busy state and
// issues one command per clock to both address sides. Also registers the
// burst and transfer done pulses.
// Assumes: size inputs are held stable while busy; start overrides step.
module dma_ag_seq
    import dma_ag_pkg::*;
#(
    parameter int BURST_W = 5,
    parameter int XFER_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               step,
    input  logic [BURST_W-1:0] burst_size,
    input  logic [XFER_W-1:0]  xfer_size,
    output ag_cmd_e            cmd,
    output logic               busy,
    output logic               burst_done,
    output logic               xfer_done
);
    logic [BURST_W-1:0] word_left;
    logic [XFER_W-1:0]  burst_left;

    // Decode which stepping level the current word belongs to.
    always_comb begin
        if (start || !busy || !step)
            cmd = CMD_IDLE;
        else if (word_left != '0)
            cmd = CMD_WORD;
        else if (burst_left != '0)
            cmd = CMD_BURST;
        else
            cmd = CMD_LAST;
    end

    // Count down words and bursts; track busy and raise done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_left  <= '0;
            burst_left <= '0;
            busy       <= 1'b0;
            burst_done <= 1'b0;
            xfer_done  <= 1'b0;
        end else begin
            burst_done <= (cmd == CMD_BURST) || (cmd == CMD_LAST);
            xfer_done  <= (cmd == CMD_LAST);
            if (start) begin
                busy       <= 1'b1;
                word_left  <= burst_size;
                burst_left <= xfer_size;
            end else begin
                case (cmd)
                    CMD_WORD:  word_left <= word_left - 1'b1;
                    CMD_BURST: begin
                        word_left  <= burst_size;
                        burst_left <= burst_left - 1'b1;
                    end
                    CMD_LAST:  busy <= 1'b0;
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_ag_side.sv
// Module: dma_ag_side
// One address side (source or destination): active begin address, active
// current address and wrap counter. Applies burst, transfer or wrap steps as
// the sequencer commands; a resync pulse reloads the wrap counter.
// Assumes: ADDR_W > STEP_W; steps are two's complement and sign-extended.
module dma_ag_side
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  ag_cmd_e           cmd,
    input  logic              resync,
    input  logic [ADDR_W-1:0] shadow_beg,
    input  logic [ADDR_W-1:0] shadow_addr,
    input  logic [STEP_W-1:0] burst_step,
    input  logic [STEP_W-1:0] xfer_step,
    input  logic [WRAP_W-1:0] wrap_size,
    input  logic [STEP_W-1:0] wrap_step,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] beg;
    logic [WRAP_W-1:0] wrap_left;
    logic [ADDR_W-1:0] burst_inc, xfer_inc, wrap_inc, next_beg;

    // Sign-extend the three step values and form the next begin address.
    always_comb begin
        burst_inc = {{EXT_W{burst_step[STEP_W-1]}}, burst_step};
        xfer_inc  = {{EXT_W{xfer_step[STEP_W-1]}},  xfer_step};
        wrap_inc  = {{EXT_W{wrap_step[STEP_W-1]}},  wrap_step};
        next_beg  = beg + wrap_inc;
    end

    // Update active addresses and the wrap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beg       <= '0;
            addr      <= '0;
            wrap_left <= '0;
        end else if (load) begin
            beg       <= shadow_beg;
            addr      <= shadow_addr;
            wrap_left <= wrap_size;
        end else begin
            case (cmd)
                CMD_WORD:  addr <= addr + burst_inc;
                CMD_BURST: begin
                    if (wrap_left == '0) begin
                        beg       <= next_beg;
                        addr      <= next_beg;
                        wrap_left <= wrap_size;
                    end else begin
                        addr      <= addr + xfer_inc;
                        wrap_left <= wrap_left - 1'b1;
                    end
                end
                default:   ;
            endcase
            if (resync)
                wrap_left <= wrap_size;
        end
    end
endmodule

// File: rtl/dma_addr_gen.sv
// Module: dma_addr_gen (top)
// Per-channel DMA address generator: one sequencer driving a source and a
// destination address side built by a generate loop. Routes the sync pulse
// to the selected side and aligns the outputs in 32-bit word mode.
// Assumes: configuration inputs are stable during a transfer.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int STEP_W  = 16,
    parameter int WRAP_W  = 16,
    parameter int BURST_W = 5,
    parameter int XFER_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               step,
    input  logic               sync_in,
    input  logic               sync_en,
    input  logic               sync_sel,
    input  logic               wide,
    input  logic [BURST_W-1:0] burst_size,
    input  logic [XFER_W-1:0]  xfer_size,
    input  logic [ADDR_W-1:0]  src_beg_sh,
    input  logic [ADDR_W-1:0]  src_addr_sh,
    input  logic [ADDR_W-1:0]  dst_beg_sh,
    input  logic [ADDR_W-1:0]  dst_addr_sh,
    input  logic [STEP_W-1:0]  src_burst_step,
    input  logic [STEP_W-1:0]  dst_burst_step,
    input  logic [STEP_W-1:0]  src_xfer_step,
    input  logic [STEP_W-1:0]  dst_xfer_step,
    input  logic [WRAP_W-1:0]  src_wrap_size,
    input  logic [WRAP_W-1:0]  dst_wrap_size,
    input  logic [STEP_W-1:0]  src_wrap_step,
    input  logic [STEP_W-1:0]  dst_wrap_step,
    output logic               busy,
    output logic               burst_done,
    output logic               xfer_done,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr
);
    ag_cmd_e           cmd;
    logic              sync_hit;
    logic [ADDR_W-1:0] sh_beg     [NUM_SIDES];
    logic [ADDR_W-1:0] sh_addr    [NUM_SIDES];
    logic [STEP_W-1:0] b_step     [NUM_SIDES];
    logic [STEP_W-1:0] t_step     [NUM_SIDES];
    logic [WRAP_W-1:0] w_size     [NUM_SIDES];
    logic [STEP_W-1:0] w_step     [NUM_SIDES];
    logic [ADDR_W-1:0] side_addr  [NUM_SIDES];
    logic [ADDR_W-1:0] shown_addr [NUM_SIDES];

    // Gather per-side configuration into arrays indexed by side.
    assign sh_beg[SIDE_SRC]  = src_beg_sh;
    assign sh_beg[SIDE_DST]  = dst_beg_sh;
    assign sh_addr[SIDE_SRC] = src_addr_sh;
    assign sh_addr[SIDE_DST] = dst_addr_sh;
    assign b_step[SIDE_SRC]  = src_burst_step;
    assign b_step[SIDE_DST]  = dst_burst_step;
    assign t_step[SIDE_SRC]  = src_xfer_step;
    assign t_step[SIDE_DST]  = dst_xfer_step;
    assign w_size[SIDE_SRC]  = src_wrap_size;
    assign w_size[SIDE_DST]  = dst_wrap_size;
    assign w_step[SIDE_SRC]  = src_wrap_step;
    assign w_step[SIDE_DST]  = dst_wrap_step;

    // Sync acts only when enabled and a transfer is running.
    assign sync_hit = sync_in && sync_en && busy && !start;

    dma_ag_seq #(
        .BURST_W (BURST_W),
        .XFER_W  (XFER_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (step),
        .burst_size (burst_size),
        .xfer_size  (xfer_size),
        .cmd        (cmd),
        .busy       (busy),
        .burst_done (burst_done),
        .xfer_done  (xfer_done)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        localparam logic SIDE_BIT = (g == SIDE_DST);
        logic resync;

        // Route the sync pulse to the side named by sync_sel.
        assign resync = sync_hit && (sync_sel == SIDE_BIT);

        dma_ag_side #(
            .ADDR_W (ADDR_W),
            .STEP_W (STEP_W),
            .WRAP_W (WRAP_W)
        ) u_side (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (start),
            .cmd         (cmd),
            .resync      (resync),
            .shadow_beg  (sh_beg[g]),
            .shadow_addr (sh_addr[g]),
            .burst_step  (b_step[g]),
            .xfer_step   (t_step[g]),
            .wrap_size   (w_size[g]),
            .wrap_step   (w_step[g]),
            .addr        (side_addr[g])
        );

        // Force even addresses in 32-bit word mode.
        assign shown_addr[g] = wide ? {side_addr[g][ADDR_W-1:1], 1'b0} : side_addr[g];
    end

    assign src_addr = shown_addr[SIDE_SRC];
    assign dst_addr = shown_addr[SIDE_DST];
endmodule

// File: rtl/dma_addr_gen_chk.sv
// Module: dma_addr_gen_chk
// Temporal checks on the generator's ports, bound to every dma_addr_gen.
module dma_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wide,
    input logic              busy,
    input logic              burst_done,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr
);
    // R7
    xfer_with_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> burst_done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !busy);

    // R7
    xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !burst_done);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!$stable(wide) || ($stable(src_addr) && $stable(dst_addr))));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wide       (wide),
    .busy       (busy),
    .burst_done (burst_done),
    .xfer_done  (xfer_done),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr)
);

// File: tb/dma_addr_gen_tb.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module dma_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, step = 1'b0, sync_in = 1'b0;
    logic        sync_en = 1'b0, sync_sel = 1'b0, wide = 1'b0;
    logic [4:0]  bsize = '0;
    logic [15:0] tsize = '0;
    logic [31:0] sh_beg [2];
    logic [31:0] sh_addr [2];
    logic [15:0] bstep [2];
    logic [15:0] tstep [2];
    logic [15:0] wsize [2];
    logic [15:0] wstep [2];
    logic        busy, burst_done, xfer_done;
    logic [31:0] src_addr, dst_addr;

    int    n_chk = 0, n_fail = 0;
    int    n_bd = 0, n_xd = 0;
    string tag = "R1";

    // reference model state
    bit          m_busy, m_bd, m_xd;
    int          m_b, m_t;
    int          m_w [2];
    logic [31:0] m_addr [2];
    logic [31:0] m_beg [2];

    always #5 clk = ~clk;

    dma_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .sync_in(sync_in), .sync_en(sync_en), .sync_sel(sync_sel), .wide(wide),
        .burst_size(bsize), .xfer_size(tsize),
        .src_beg_sh(sh_beg[0]), .src_addr_sh(sh_addr[0]),
        .dst_beg_sh(sh_beg[1]), .dst_addr_sh(sh_addr[1]),
        .src_burst_step(bstep[0]), .dst_burst_step(bstep[1]),
        .src_xfer_step(tstep[0]), .dst_xfer_step(tstep[1]),
        .src_wrap_size(wsize[0]), .dst_wrap_size(wsize[1]),
        .src_wrap_step(wstep[0]), .dst_wrap_step(wstep[1]),
        .busy(busy), .burst_done(burst_done), .xfer_done(xfer_done),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] shown(input logic [31:0] a);
        return wide ? (a & 32'hFFFF_FFFE) : a;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge from the applied inputs.
    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n) begin
            m_busy = 0; m_bd = 0; m_xd = 0; m_b = 0; m_t = 0;
            for (int s = 0; s < 2; s++) begin
                m_w[s] = 0; m_addr[s] = '0; m_beg[s] = '0;
            end
        end else begin
            was_busy = m_busy;
            m_bd = 0; m_xd = 0;
            if (start) begin
                m_busy = 1; m_b = int'(bsize); m_t = int'(tsize);
                for (int s = 0; s < 2; s++) begin
                    m_addr[s] = sh_addr[s]; m_beg[s] = sh_beg[s]; m_w[s] = int'(wsize[s]);
                end
            end else if (m_busy && step) begin
                if (m_b > 0) begin
                    m_b--;
                    for (int s = 0; s < 2; s++) m_addr[s] = m_addr[s] + sx(bstep[s]);
                end else begin
                    m_bd = 1;
                    if (m_t == 0) begin
                        m_xd = 1; m_busy = 0;
                    end else begin
                        m_t--; m_b = int'(bsize);
                        for (int s = 0; s < 2; s++) begin
                            if (m_w[s] == 0) begin
                                m_beg[s] = m_beg[s] + sx(wstep[s]);
                                m_addr[s] = m_beg[s];
                                m_w[s] = int'(wsize[s]);
                            end else begin
                                m_addr[s] = m_addr[s] + sx(tstep[s]);
                                m_w[s]--;
                            end
                        end
                    end
                end
            end
            if (sync_in && sync_en && was_busy && !start)
                m_w[sync_sel] = int'(wsize[sync_sel]);
        end
    end

    // Per-clock comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(src_addr == shown(m_addr[0]), tag, "src_addr", src_addr, shown(m_addr[0]));
            check(dst_addr == shown(m_addr[1]), tag, "dst_addr", dst_addr, shown(m_addr[1]));
            check(busy == m_busy, tag, "busy", 32'(busy), 32'(m_busy));
            check(burst_done == m_bd, "R7", "burst_done", 32'(burst_done), 32'(m_bd));
            check(xfer_done == m_xd, "R7", "xfer_done", 32'(xfer_done), 32'(m_xd));
            if (burst_done) n_bd++;
            if (xfer_done)  n_xd++;
        end
    end

    // One cycle of stimulus, applied shortly after the falling edge.
    task automatic cyc(input bit st, input bit sy);
        @(negedge clk);
        #2;
        start = 1'b0; step = st; sync_in = sy;
    endtask

    task automatic go();
        @(negedge clk);
        #2;
        start = 1'b1; step = 1'b1; sync_in = 1'b0;
        n_bd = 0; n_xd = 0;
        cyc(0, 0);
    endtask

    task automatic run_to_end(input int gap_mod, input int sync_every);
        for (int i = 0; i < 400 && busy; i++)
            cyc(gap_mod == 0 ? 1'b1 : (($urandom % gap_mod) != 0),
                sync_every != 0 && (i % sync_every) == 3);
        cyc(0, 0);
    endtask

    task automatic cfg_a();
        bsize = 5'd2; tsize = 16'd4;
        sh_beg[0] = 32'h1000; sh_addr[0] = 32'h1000;
        bstep[0] = 16'h0001; tstep[0] = 16'h0002; wsize[0] = 16'd1; wstep[0] = 16'h0100;
        sh_beg[1] = 32'h2000; sh_addr[1] = 32'h2000;
        bstep[1] = 16'hFFFF; tstep[1] = 16'h0010; wsize[1] = 16'd3; wstep[1] = 16'hFFC0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] hold_s, hold_d;
        for (int s = 0; s < 2; s++) begin
            sh_beg[s] = '0; sh_addr[s] = '0; bstep[s] = '0;
            tstep[s] = '0; wsize[s] = '0; wstep[s] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check(busy == 1'b0 && burst_done == 1'b0 && xfer_done == 1'b0, "R1", "flags in reset",
              {29'd0, busy, burst_done, xfer_done}, 32'd0);
        check(src_addr == 0 && dst_addr == 0, "R1", "addresses in reset", src_addr | dst_addr, 32'd0);
        #2 rst_n = 1'b1;

        // R2: start loads shadows
        tag = "R2"; cfg_a(); go();
        check(src_addr == 32'h1000 && dst_addr == 32'h2000, "R2", "loaded src", src_addr, 32'h1000);
        check(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);

        // R3, R4, R5: six back-to-back words
        tag = "R4";
        repeat (6) cyc(1, 0);
        cyc(0, 0);
        check(src_addr == 32'h1100, "R5", "src after wrap", src_addr, 32'h1100);
        check(dst_addr == 32'h201C, "R4", "dst after two bursts", dst_addr, 32'h201C);
        repeat (9) cyc(1, 0);
        cyc(0, 0);
        check(n_bd == 5, "R7", "burst pulse count", 32'(n_bd), 32'd5);
        check(n_xd == 1, "R7", "transfer pulse count", 32'(n_xd), 32'd1);
        check(busy == 1'b0, "R8", "idle after final word", 32'(busy), 32'd0);

        // R8: steps after the end are ignored
        tag = "R8";
        hold_s = src_addr; hold_d = dst_addr;
        repeat (4) cyc(1, 0);
        cyc(0, 0);
        check(src_addr == hold_s && dst_addr == hold_d, "R8", "addresses hold", src_addr, hold_s);
        check(n_bd == 5, "R8", "no done pulse after end", 32'(n_bd), 32'd5);

        // R3: random gaps between steps, longer bursts
        tag = "R3";
        bsize = 5'd3; tsize = 16'd6; wsize[0] = 16'd2; wsize[1] = 16'd0;
        bstep[0] = 16'hFFFE; tstep[1] = 16'hFF00;
        go(); run_to_end(3, 0);
        check(n_bd == 7 && n_xd == 1, "R7", "pulses with gaps", 32'(n_bd), 32'd7);

        // R6: sync realignment, directed
        tag = "R6";
        bsize = 5'd0; tsize = 16'd9;
        sh_beg[1] = 32'h0; sh_addr[1] = 32'h0; tstep[1] = 16'h0001;
        wsize[1] = 16'd1; wstep[1] = 16'h0100;
        sync_en = 1'b1; sync_sel = 1'b1;
        go(); cyc(1, 0); cyc(0, 1); cyc(1, 0); cyc(0, 0);
        check(dst_addr == 32'h2, "R6", "sync delays dst wrap", dst_addr, 32'h2);
        sync_sel = 1'b0;
        go(); cyc(1, 0); cyc(0, 1); cyc(1, 0); cyc(0, 0);
        check(dst_addr == 32'h100, "R6", "sync on other side", dst_addr, 32'h100);
        sync_en = 1'b0; sync_sel = 1'b1;
        go(); cyc(1, 0); cyc(0, 1); cyc(1, 0); cyc(0, 0);
        check(dst_addr == 32'h100, "R6", "sync disabled", dst_addr, 32'h100);
        run_to_end(0, 0);
        // longer sync run compared every clock
        sync_en = 1'b1; bsize = 5'd1; tsize = 16'd20; wsize[1] = 16'd2; wsize[0] = 16'd1;
        go(); run_to_end(0, 5);
        sync_sel = 1'b0; go(); run_to_end(2, 4);
        sync_en = 1'b0;

        // R2: restart in the middle of a transfer
        tag = "R2";
        cfg_a(); go(); repeat (4) cyc(1, 0);
        sh_addr[0] = 32'h5555_0000; go();
        check(src_addr == 32'h5555_0000, "R2", "restart reloads", src_addr, 32'h5555_0000);
        run_to_end(0, 0);
        check(n_bd == 5, "R2", "restart reloads counters", 32'(n_bd), 32'd5);

        // R9: wide mode aligns odd addresses
        tag = "R9";
        wide = 1'b1; sh_addr[0] = 32'h3001; sh_beg[0] = 32'h3001;
        go();
        check(src_addr == 32'h3000, "R9", "even src in wide", src_addr, 32'h3000);
        run_to_end(0, 0);
        check(src_addr[0] == 1'b0 && dst_addr[0] == 1'b0, "R9", "bit0 after run",
              {30'd0, src_addr[0], dst_addr[0]}, 32'd0);
        wide = 1'b0;

        // R7: one-word transfer boundary
        tag = "R7";
        bsize = 5'd0; tsize = 16'd0;
        go(); cyc(1, 0); cyc(0, 0);
        check(burst_done && xfer_done && !busy, "R7", "single word done",
              {29'd0, burst_done, xfer_done, busy}, 32'd6);

        cyc(0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule